// File: doc/BRIEF.md
# Sampled Multi-Size Cache Miss Profiler

The block watches the access stream of a last-level cache and estimates, during one measurement interval, how many misses the cache would take at five sizes: the present size and one half, one quarter, one eighth and one sixteenth of it. Each size has its own shadow directory. A shadow directory holds tags only, keeps the same associativity as the real cache, uses 64-byte lines and applies true LRU replacement. To keep the storage small, only one set in sixty-four is shadowed. A smaller emulated size has fewer sets, so it also has proportionally fewer sampled sets.

Accesses arrive on a valid/ready stream. `acc_ready` is low while reset is applied and from the first clock after reset it stays high. The profiler never applies back-pressure, so an access is taken in every cycle where `acc_valid` is high. Each size has two saturating counters: one for all misses and one for misses of accesses marked as loads. A one-cycle `interval_start` pulse copies every live counter into its read register and restarts the live counters. Whatever consumes the counts reads the read registers at leisure until the next pulse.

Top module: `sampled_miss_profiler`

## Requirements
- R1: An access is profiled only when address bits [11:6] (the low six set-index bits) are all zero. Any other access changes no counter and no directory.
- R2: Unit k (k = 0 is the full size) emulates 4096>>k sets of 8 ways with 64-byte lines. Its sampled set is chosen by address bits [12 +: 6-k], and a line is identified by address bits [31:6].
- R3: A profiled access whose line is absent from its unit's sampled set counts one miss in that unit. The line is installed in the least recently used way and becomes most recently used.
- R4: A profiled access whose line is present counts nothing and makes that line most recently used.
- R5: Empty ways are filled before any valid line is evicted. Once a set holds 8 lines, a miss evicts the least recently used line.
- R6: The load-miss counter of a unit counts only misses with `acc_load` = 1. A miss with `acc_load` = 0 counts only in the total.
- R7: On `interval_start`, every live count is copied to its read output, where it is visible from the next cycle. The live counts restart at the same time, and read outputs hold between pulses.
- R8: A miss in the same cycle as `interval_start` belongs to the new interval. It is absent from the value just latched and present in the next one.
- R9: Counters saturate at 2^CNT_W-1 and never wrap.
- R10: After reset all read outputs are zero and every directory is empty.
- R11: An access is taken only when `acc_valid` and `acc_ready` are both high. `acc_ready` is low in reset and high in every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is offered |
| acc_ready | output | 1 | Profiler can take an access (high after reset) |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_load | input | 1 | 1 = load, 0 = store |
| interval_start | input | 1 | One-cycle pulse: latch counts and restart them |
| rd_miss | output | NUM_UNITS*CNT_W | Latched miss counts; unit k at [k*CNT_W +: CNT_W] |
| rd_load_miss | output | NUM_UNITS*CNT_W | Latched load-miss counts, same packing |

## Verification
An interval pulse and a profiled access that misses can arrive in the same cycle. The bench provokes this on purpose, with a missing load issued together with the pulse and also with random pulses during mixed traffic. It then judges the result against a behavioural model that closes the old interval before it counts the new access. The latched value must exclude that miss, and the following latch must include it. A second coincidence is saturation meeting a pulse: a counter held at its ceiling must latch the ceiling and restart at 0 or 1.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int unsigned SMP_NUM_UNITS   = 5;
  localparam int unsigned SMP_ADDR_W      = 32;
  localparam int unsigned SMP_LINE_BYTES  = 64;
  localparam int unsigned SMP_FULL_SETS   = 4096;
  localparam int unsigned SMP_WAYS        = 8;
  localparam int unsigned SMP_SAMPLE_W    = 6;
  localparam int unsigned SMP_CNT_W       = 32;

  // sampled sets for the unit that emulates full_sets >> k
  function automatic int unsigned smp_sampled_sets(input int unsigned full_sets,
                                                   input int unsigned k,
                                                   input int unsigned sample_w);
    return (full_sets >> k) >> sample_w;
  endfunction
endpackage

// File: rtl/smp_sat_counter.sv
module smp_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] rd_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      rd_val <= '0;
    end else if (clear) begin
      rd_val <= live_q;
      live_q <= CNT_W'(inc);
    end else if (inc && live_q != CNT_MAX) begin
      live_q <= live_q + 1'b1;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == CNT_MAX && !clear) |=> live_q == CNT_MAX); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> live_q <= CNT_W'(1)); // R7
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> $stable(rd_val)); // R7
endmodule

// File: rtl/smp_shadow_unit.sv
module smp_shadow_unit #(
  parameter int unsigned HI_W = 20,
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            probe,
  input  logic [HI_W-1:0] line_hi,
  output logic            miss
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [HI_W-1:0]  tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic [SET_W-1:0] set_sel;
  logic [WAYS-1:0]  hit_vec, old_vec;
  logic [WAY_W-1:0] hit_way, vict_way, touch_way, ref_age;
  logic             hit;

  assign set_sel = line_hi[SET_W-1:0];

  always_comb begin
    hit_vec  = '0;
    old_vec  = '0;
    hit_way  = '0;
    vict_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[set_sel][w] && (tag_q[set_sel][w] == line_hi);
      old_vec[w] = (age_q[set_sel][w] == WAY_W'(WAYS-1));
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (old_vec[w]) vict_way = WAY_W'(w);
    end
    hit       = |hit_vec;
    touch_way = hit ? hit_way : vict_way;
    ref_age   = age_q[set_sel][touch_way];
  end

  assign miss = probe && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (probe) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[set_sel][w] <= '0;
        else if (age_q[set_sel][w] < ref_age)
          age_q[set_sel][w] <= age_q[set_sel][w] + 1'b1;
      end
      if (!hit) begin
        vld_q[set_sel][touch_way] <= 1'b1;
        tag_q[set_sel][touch_way] <= line_hi;
      end
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    probe |-> $onehot0(hit_vec)); // R4
  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    probe |-> $countones(old_vec) == 1); // R5
endmodule

// File: rtl/sampled_miss_profiler.sv
module sampled_miss_profiler
  import smp_pkg::*;
#(
  parameter int unsigned NUM_UNITS  = SMP_NUM_UNITS,
  parameter int unsigned ADDR_W     = SMP_ADDR_W,
  parameter int unsigned LINE_BYTES = SMP_LINE_BYTES,
  parameter int unsigned FULL_SETS  = SMP_FULL_SETS,
  parameter int unsigned WAYS       = SMP_WAYS,
  parameter int unsigned SAMPLE_W   = SMP_SAMPLE_W,
  parameter int unsigned CNT_W      = SMP_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  output logic                       acc_ready,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       acc_load,
  input  logic                       interval_start,
  output logic [NUM_UNITS*CNT_W-1:0] rd_miss,
  output logic [NUM_UNITS*CNT_W-1:0] rd_load_miss
);
  localparam int unsigned OFFSET_W = $clog2(LINE_BYTES);
  localparam int unsigned HI_LSB   = OFFSET_W + SAMPLE_W;
  localparam int unsigned HI_W     = ADDR_W - HI_LSB;

  logic                 fire, sampled, probe;
  logic [NUM_UNITS-1:0] miss_vec;
  logic                 unused_offset_bits;

  assign unused_offset_bits = ^acc_addr[OFFSET_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) acc_ready <= 1'b0;
    else        acc_ready <= 1'b1;
  end

  assign fire    = acc_valid && acc_ready;
  assign sampled = (acc_addr[OFFSET_W +: SAMPLE_W] == '0);
  assign probe   = fire && sampled;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    localparam int unsigned USETS = smp_sampled_sets(FULL_SETS, k, SAMPLE_W);

    smp_shadow_unit #(.HI_W(HI_W), .SETS(USETS), .WAYS(WAYS)) dir_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .probe   (probe),
      .line_hi (acc_addr[ADDR_W-1:HI_LSB]),
      .miss    (miss_vec[k])
    );

    smp_sat_counter #(.CNT_W(CNT_W)) all_cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (interval_start),
      .inc    (miss_vec[k]),
      .rd_val (rd_miss[k*CNT_W +: CNT_W])
    );

    smp_sat_counter #(.CNT_W(CNT_W)) ld_cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (interval_start),
      .inc    (miss_vec[k] && acc_load),
      .rd_val (rd_load_miss[k*CNT_W +: CNT_W])
    );

    AST_LOAD_LE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load_miss[k*CNT_W +: CNT_W] <= rd_miss[k*CNT_W +: CNT_W]); // R6
  end

  AST_SKIP_UNSAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sampled) |-> miss_vec == '0); // R1
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> acc_ready); // R11
  AST_IDLE_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> miss_vec == '0); // R11
endmodule

// File: tb/sampled_miss_profiler_tb.sv
`timescale 1ns/1ps
module sampled_miss_profiler_tb_top;
  localparam int NU = 5;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [31:0] acc_addr = '0;
  logic acc_load = 1'b0;
  logic interval_start = 1'b0;
  logic [NU*CW-1:0] rd_miss, rd_load_miss;

  always #2 clk = ~clk;

  sampled_miss_profiler #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_load(acc_load), .interval_start(interval_start),
    .rd_miss(rd_miss), .rd_load_miss(rd_load_miss)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R10";

  // behavioural model: per unit and sampled set, MRU-first list of line addresses
  logic [25:0] mq [NU][64][$];
  int live_m [NU], live_l [NU], rd_m [NU], rd_l [NU];

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat_inc(int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic model_step(bit v, logic [31:0] a, bit ld, bit pulse);
    if (pulse) begin
      for (int k = 0; k < NU; k++) begin
        rd_m[k] = live_m[k]; rd_l[k] = live_l[k];
        live_m[k] = 0; live_l[k] = 0;
      end
    end
    if (v && a[11:6] == 6'd0) begin
      for (int k = 0; k < NU; k++) begin
        int s;
        int pos;
        s = int'(a >> 12) & ((64 >> k) - 1);
        pos = -1;
        for (int i = 0; i < mq[k][s].size(); i++)
          if (mq[k][s][i] == a[31:6]) pos = i;
        if (pos >= 0) begin
          mq[k][s].delete(pos);
          mq[k][s].push_front(a[31:6]);
        end else begin
          mq[k][s].push_front(a[31:6]);
          if (mq[k][s].size() > 8) void'(mq[k][s].pop_back());
          live_m[k] = sat_inc(live_m[k]);
          if (ld) live_l[k] = sat_inc(live_l[k]);
        end
      end
    end
  endtask

  task automatic compare_all();
    chk({cur_tag, " R11 ready"}, int'(acc_ready), 1);
    for (int k = 0; k < NU; k++) begin
      chk($sformatf("%s R7 miss u%0d", cur_tag, k), int'(rd_miss[k*CW +: CW]), rd_m[k]);
      chk($sformatf("%s R6 load u%0d", cur_tag, k), int'(rd_load_miss[k*CW +: CW]), rd_l[k]);
    end
  endtask

  // inputs driven at negedge; model advanced at the edge; outputs compared at next negedge
  task automatic step(bit v, logic [31:0] a, bit ld, bit pulse);
    acc_valid = v; acc_addr = a; acc_load = ld; interval_start = pulse;
    @(posedge clk);
    model_step(v, a, ld, pulse);
    @(negedge clk);
    acc_valid = 1'b0; interval_start = 1'b0;
    compare_all();
  endtask

  task automatic latch();
    step(1'b0, 32'd0, 1'b0, 1'b1);
  endtask

  function automatic logic [31:0] line(int t, int setf);
    return (32'(t) << 18) | (32'(setf) << 12);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NU; k++) begin
      live_m[k] = 0; live_l[k] = 0; rd_m[k] = 0; rd_l[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R11 ready low in reset", int'(acc_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    cur_tag = "R10";
    compare_all();
    chk("R10 read zero", int'(rd_miss), 0);

    // R1: unsampled accesses leave everything untouched
    cur_tag = "R1";
    for (int i = 1; i < 40; i++) step(1'b1, line(i, 0) | (32'(i % 63 + 1) << 6), 1'b1, 1'b0);
    latch();
    for (int k = 0; k < NU; k++) chk("R1 no count", int'(rd_miss[k*CW +: CW]), 0);

    // R3/R4: fill 8 lines then revisit
    cur_tag = "R3";
    for (int i = 0; i < 8; i++) step(1'b1, line(i + 1, 0) | 32'h15, 1'b0, 1'b0);
    latch();
    for (int k = 0; k < NU; k++) chk("R3 eight misses", int'(rd_miss[k*CW +: CW]), 8);
    cur_tag = "R4";
    for (int i = 0; i < 8; i++) step(1'b1, line(i + 1, 0), 1'b1, 1'b0);
    latch();
    for (int k = 0; k < NU; k++) chk("R4 all hits", int'(rd_miss[k*CW +: CW]), 0);

    // R5: ninth line evicts LRU (line 1), line 2 still present
    cur_tag = "R5";
    step(1'b1, line(9, 0), 1'b0, 1'b0);
    step(1'b1, line(2, 0), 1'b0, 1'b0);
    step(1'b1, line(1, 0), 1'b0, 1'b0);
    latch();
    chk("R5 evicted LRU", int'(rd_miss[0 +: CW]), 2);

    // R6: loads vs stores
    cur_tag = "R6";
    for (int i = 0; i < 5; i++) step(1'b1, line(20 + i, 1), (i < 3), 1'b0);
    latch();
    chk("R6 total", int'(rd_miss[0 +: CW]), 5);
    chk("R6 loads", int'(rd_load_miss[0 +: CW]), 3);

    // R2: bit 17 splits sets only for the full-size unit
    cur_tag = "R2";
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 10; i++) step(1'b1, line(40 + i % 5, (i < 5) ? 0 : 32), 1'b0, 1'b0);
    latch();
    chk("R2 full size", int'(rd_miss[0 +: CW]), 10);
    for (int k = 1; k < NU; k++) chk("R2 smaller size", int'(rd_miss[k*CW +: CW]), 20);

    // R8: miss coincident with pulse goes to the new interval
    cur_tag = "R8";
    step(1'b1, line(60, 2), 1'b0, 1'b0);
    step(1'b1, line(61, 2), 1'b1, 1'b1);
    chk("R8 old interval", int'(rd_miss[0 +: CW]), 1);
    latch();
    chk("R8 new interval", int'(rd_miss[0 +: CW]), 1);
    chk("R8 new interval load", int'(rd_load_miss[0 +: CW]), 1);

    // R9: saturation
    cur_tag = "R9";
    for (int i = 0; i < 300; i++) step(1'b1, line(100 + i, 3), 1'b1, 1'b0);
    latch();
    chk("R9 saturated", int'(rd_miss[4*CW +: CW]), CMAX);
    chk("R9 saturated load", int'(rd_load_miss[0 +: CW]), CMAX);

    // random mix with coincident pulses
    cur_tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      a = (32'($urandom % 14) << 18) | (32'($urandom & 32'h23) << 12) | 32'($urandom % 64);
      if ($urandom % 6 == 0) a[11:6] = 6'($urandom);
      step(($urandom % 4) != 0, a, $urandom % 2 == 1, ($urandom % 50) == 0);
    end
    latch();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule